// File: doc/BRIEF.md
# Oversampling Serial Receiver with Fractional Bit Timing

This block recovers asynchronous 8N1 characters from a serial line. Each bit is divided into a fixed number of sample slots, set by the parameter `OSR`. A slot normally lasts `floor(div/OSR)` clock cycles, where `div` is the programmed baud divisor. The remainder `div mod OSR` is not discarded. Instead, the highest-numbered slots of every bit each take one extra cycle. As a result, every bit lasts exactly `div` clocks, and no phase error builds up across a character, even when the divisor is only slightly larger than `OSR`.

The raw line passes through two synchronizer flops before any sampling logic sees it. A falling edge while idle opens a character. A bit is decided by a vote over the three slots around the bit centre. The assembled byte appears on `data_o` together with a one-cycle `valid_o` strobe, and a stop-bit fault is reported on `frame_err_o`.

Top module: `frac_baud_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it, `valid_o` is 0, `data_o` is 8'h00 and `frame_err_o` is 0.
- R2: Every bit of a character lasts exactly `div` cycles for any `div >= OSR`, so characters are received correctly at divisors from `OSR` to `5*OSR`, whether or not `div` is a multiple of `OSR`.
- R3: A slot lasts `base = floor(div/OSR)` cycles, plus one cycle for slots with index `>= OSR - (div mod OSR)`. Slots are numbered 0 to OSR-1 within each bit.
- R4: Data bits are taken LSB first: the first bit after the start bit lands in `data_o[0]`. `data_o` changes only together with `valid_o`.
- R5: A bit value is the majority of the samples taken at the ends of slots `OSR/2-1`, `OSR/2` and `OSR/2+1`. A disturbance that corrupts only one of these samples does not change the bit.
- R6: If the line reads high at the end of slot `OSR/2` of the start bit, the character is abandoned and no strobe is produced. A later character is still received normally.
- R7: The stop bit is judged by the same vote. If it reads low, `frame_err_o` is 1 alongside the strobe; otherwise `frame_err_o` is 0. `frame_err_o` changes only with `valid_o`.
- R8: Exactly one single-cycle `valid_o` pulse is produced per character. It is issued on the clock edge `3 + 9*div + E` cycles after the first edge at which the raw line is low, where `E` is the sum of the lengths of slots 0 to `OSR/2+1`, minus one.
- R9: The divisor is captured when the start edge is detected; changing `div_i` during a character does not affect that character.
- R10: While `en_i` is low the receiver stays idle and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Raw asynchronous serial line, idle high |
| div_i | input | DIV_W | Clock cycles per bit, must be at least OSR |
| en_i | input | 1 | Receiver enable |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe when `data_o` is updated |
| frame_err_o | output | 1 | Stop bit of the last byte read low |

## Verification
On every cycle, the assertions check that the strobe never lasts more than one cycle and that the outputs hold between strobes. They also check that nothing is strobed while the block is disabled, that reset clears the outputs, and that the slot counter never passes the stretched slot length. What they cannot show is whether the bit timing is exact. The bench sweeps every divisor across a wide range with several byte patterns and predicts the strobe cycle arithmetically from the slot-length rule, so a dropped or misplaced remainder cycle appears as a wrong byte or a shifted strobe. Separate scenarios cover the centre-slot vote, aborted false starts, stop-bit errors, a divisor change in mid-character, and operation while disabled.

// File: rtl/frac_baud_rx.sv
module frac_baud_rx #(
  parameter int OSR   = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             frame_err_o
);
  localparam int SW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  st_t              state;
  logic [1:0]       rx_sync;
  logic             rx_q;
  logic [DIV_W-1:0] div_l, cnt;
  logic [SW-1:0]    slot;
  logic [2:0]       nbit;
  logic [1:0]       samp;
  logic [7:0]       shreg;

  wire              rx_s    = rx_sync[1];
  wire [DIV_W-1:0]  base    = div_l / DIV_W'(OSR);
  wire [DIV_W-1:0]  rem     = div_l % DIV_W'(OSR);
  wire              stretch = (32'(slot) + 32'(rem)) >= OSR;
  wire [DIV_W-1:0]  len     = base + DIV_W'(stretch);
  wire              last    = (cnt == len - 1'b1);
  wire              maj     = (samp[1] & samp[0]) | (samp[1] & rx_s) | (samp[0] & rx_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= IDLE;
      rx_sync     <= 2'b11;
      rx_q        <= 1'b1;
      div_l       <= '0;
      cnt         <= '0;
      slot        <= '0;
      nbit        <= '0;
      samp        <= '0;
      shreg       <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      rx_sync <= {rx_sync[0], rx_i};
      rx_q    <= rx_s;
      if (!en_i) begin
        state <= IDLE;
      end else if (state == IDLE) begin
        if (!rx_s && rx_q) begin
          state <= START;
          div_l <= div_i;
          cnt   <= '0;
          slot  <= '0;
          nbit  <= '0;
        end
      end else begin
        if (last) begin
          cnt  <= '0;
          slot <= (slot == SW'(OSR-1)) ? '0 : slot + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (last && (slot == SW'(MID-1) || slot == SW'(MID)))
          samp <= {samp[0], rx_s};
        if (last && slot == SW'(MID) && state == START && rx_s)
          state <= IDLE;
        if (last && slot == SW'(MID+1)) begin
          if (state == DATA)
            shreg <= {maj, shreg[7:1]};
          if (state == STOP) begin
            valid_o     <= 1'b1;
            data_o      <= shreg;
            frame_err_o <= !maj;
            state       <= IDLE;
          end
        end
        if (last && slot == SW'(OSR-1)) begin
          if (state == START)
            state <= DATA;
          if (state == DATA) begin
            nbit <= nbit + 1'b1;
            if (nbit == 3'd7)
              state <= STOP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frac_baud_rx_chk.sv
module frac_baud_rx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             valid_o,
  input logic [7:0]       data_o,
  input logic             frame_err_o,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] base
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && data_o == 8'h00 && !frame_err_o));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !valid_o);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_o) |-> valid_o);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_err_o) |-> valid_o);

  // R3
  slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= base);
endmodule

bind frac_baud_rx frac_baud_rx_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/frac_baud_rx_bench.sv
module frac_baud_rx_bench;
  localparam int OSR = 8;
  localparam int DW  = 8;
  localparam int MID = OSR / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx = 1'b1;
  logic [DW-1:0] div_i = DW'(OSR);
  logic          en = 1'b1;
  logic [7:0]    data_o;
  logic          valid_o, frame_err_o;

  int vectors = 0, fails = 0, cyc = 0;
  int vcnt = 0, vcyc = 0;
  logic [7:0] vdata = 8'h00;
  logic verr = 1'b0;
  bit done = 1'b0;

  frac_baud_rx #(.OSR(OSR), .DIV_W(DW)) u_frac_baud_rx (
    .clk(clk), .rst(rst), .rx_i(rx), .div_i(div_i), .en_i(en),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (valid_o) begin
    vcnt  = vcnt + 1;
    vcyc  = cyc;
    vdata = data_o;
    verr  = frame_err_o;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int strobe_off(input int d);
    int b = d / OSR, r = d % OSR, e = 0;
    for (int j = 0; j <= MID + 1; j++) e += b + ((j >= OSR - r) ? 1 : 0);
    return 3 + 9 * d + e - 1;
  endfunction

  task automatic send(input int d, input logic [7:0] b, input logic sb,
                      input int gk, input int chg, output int c0);
    @(negedge clk);
    c0 = cyc + 1;
    for (int k = 0; k < 10; k++) begin
      logic bv;
      bv = (k == 0) ? 1'b0 : (k == 9) ? sb : b[k-1];
      for (int i = 0; i < d; i++) begin
        rx = bv ^ (k == gk && i >= 14 && i < 17);
        if (k == 4 && i == 0 && chg != 0) div_i = DW'(chg);
        @(negedge clk);
      end
    end
    rx = 1'b1;
    div_i = DW'(d);
  endtask

  task automatic frame(input string req, input int d, input logic [7:0] b,
                       input logic sb, input int gk, input int chg);
    int c0, n0;
    n0 = vcnt;
    div_i = DW'(d);
    send(d, b, sb, gk, chg, c0);
    repeat (2 * d + 8) @(negedge clk);
    check({req, " R8 strobe count"}, vcnt - n0, 1);
    check({req, " R8 R3 strobe cycle"}, vcyc - c0, strobe_off(d));
    check({req, " R2 R4 data"}, vdata, b);
    check({req, " R7 frame error"}, verr, !sb);
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", valid_o, 0);
    check("R1 data in reset", data_o, 0);
    check("R1 ferr in reset", frame_err_o, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    for (int d = OSR; d <= 5 * OSR; d++) begin
      frame("R2 sweep", d, 8'h00, 1'b1, -1, 0);
      frame("R2 sweep", d, 8'hFF, 1'b1, -1, 0);
      frame("R2 sweep", d, 8'hA5, 1'b1, -1, 0);
      frame("R4 lsb first", d, 8'h01, 1'b1, -1, 0);
      frame("R4 lsb first", d, 8'h80, 1'b1, -1, 0);
      frame("R2 sweep", d, 8'((d * 37) ^ 8'h5A), 1'b1, -1, 0);
      frame("R7 bad stop", d, 8'(d), 1'b0, -1, 0);
      frame("R7 clear after good", d, 8'h3C, 1'b1, -1, 0);
    end

    frame("R5 centre glitch", 3 * OSR, 8'hA5, 1'b1, 3, 0);
    frame("R5 centre glitch", 3 * OSR, 8'h5A, 1'b1, 6, 0);

    div_i = DW'(3 * OSR);
    n0 = vcnt;
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (12 * 3 * OSR) @(negedge clk);
    check("R6 false start no strobe", vcnt - n0, 0);
    frame("R6 after false start", 3 * OSR, 8'hC3, 1'b1, -1, 0);

    frame("R9 div change mid char", 20, 8'h96, 1'b1, -1, 37);
    frame("R9 div change mid char", 37, 8'h69, 1'b1, -1, 9);

    en = 1'b0;
    n0 = vcnt;
    begin
      int c0;
      send(16, 8'h55, 1'b1, -1, 0, c0);
    end
    repeat (40) @(negedge clk);
    check("R10 disabled no strobe", vcnt - n0, 0);
    en = 1'b1;
    repeat (10) @(negedge clk);
    frame("R10 reenabled", 16, 8'h55, 1'b1, -1, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule